// File: doc/BRIEF.md
# QoS Request Arbiter with Starvation Aging

This block decides which of several masters contending for one slave gets the next transfer slot. Every requester raises a valid flag together with a 4-bit quality-of-service level. When the slave side is idle, the arbiter registers a one-hot grant to the requester with the highest effective level. That grant then stays fixed until the downstream logic pulses a transfer-complete input. Requesters on the same effective level are served in rotating order. A rotation pointer moves to the slot just past each winner.

Each requester has a saturating wait counter. The counter counts the cycles in which that requester asks for the slot but does not hold it. Once the counter passes a parameterised limit, the requester is treated as having the top level, 15. This keeps a level-0 master from being locked out by a stream of high-level traffic. Multiplexing the address channel, decoding addresses and routing the responses belong to the logic around this block.

Top module: `qos_age_arbiter`

## Requirements
- R1: A synchronous active-high reset clears the grant to all zeros, every wait counter to 0 and the rotation pointer to slot 0.
- R2: The grant is a registered one-hot vector (bit i means requester i). When no grant is held and at least one valid flag is high at a clock edge, the grant goes to a requester that was valid at that edge and appears after that edge. With no valid flag high, the grant stays zero.
- R3: The effective level of requester i is its 4-bit level taken from bits [4i+3:4i] of the level bus, unless it is boosted (R8). Among the valid requesters, one with the largest effective level wins.
- R4: Among valid requesters sharing the top effective level, the first one found scanning upward from the pointer (wrapping from N-1 to 0) wins. After each grant the pointer becomes the winner's index plus one, modulo N.
- R5: Once a grant is given, it stays unchanged on every edge at which the done input is low, whatever the valid flags do. On an edge where done is high, the grant clears to zero. A new winner can be chosen at the edge after that at the earliest.
- R6: A requester's wait counter rises by one on each edge at which it is valid and does not hold the grant. The counter holds while the requester is not valid. It clears to 0 on the edge at which the requester is granted, and the clear takes precedence over the increment.
- R7: The wait counter saturates at 2^AGE_W-1 and never wraps back to a small value.
- R8: A requester whose wait counter is greater than AGE_LIMIT has effective level 15. Among several requesters at 15, R4 decides.
- R9: A level-0 requester that stays valid is granted within a bounded number of grants, even while level-15 requesters compete continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_REQ | Request flag per requester |
| req_qos | input | NUM_REQ*QOS_W | Packed levels, requester i at bits [QOS_W*i +: QOS_W] |
| xfer_done | input | 1 | One-cycle pulse: the granted transfer has finished |
| grant | output | NUM_REQ | Registered one-hot grant, held until done |

## Verification
Two events can fall on the same edge and collide. The first is the selection edge: there the winner's counter must clear while its valid flag, with no grant yet held, would otherwise raise it. The second is the done edge: the holder's grant drops while the other counters keep rising. The bench sets up both. It keeps a requester valid through its own grant, and it lets a counter saturate past the wrap point while another master holds the slot. Both are judged through later grants. A counter that wrapped instead of saturating would lose its boost. A counter that was not cleared would still carry one. Those grants are compared against a behavioural model on every clock.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int QOS_BITS = 4;
  localparam logic [QOS_BITS-1:0] QOS_TOP = '1;
  typedef logic [QOS_BITS-1:0] qos_t;
endpackage

// File: rtl/qos_age_cell.sv
module qos_age_cell #(
  parameter int AGE_W     = 6,
  parameter int AGE_LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic inc,
  input  logic clr,
  output logic boosted
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;
  localparam logic [AGE_W-1:0] LIMIT_V = AGE_W'(AGE_LIMIT);

  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      age_q <= '0;
    end else if (clr) begin
      age_q <= '0;
    end else if (inc && (age_q != AGE_MAX)) begin
      age_q <= age_q + 1'b1;
    end
  end

  assign boosted = (age_q > LIMIT_V);

  // R7
  age_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (age_q == AGE_MAX && inc && !clr) |=> (age_q == AGE_MAX));

  // R6
  age_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (age_q == '0));
endmodule

// File: rtl/qos_pick.sv
module qos_pick
  import qos_arb_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 2
) (
  input  logic [NUM_REQ-1:0]          valid,
  input  logic [NUM_REQ*QOS_BITS-1:0] qos,
  input  logic [NUM_REQ-1:0]          boosted,
  input  logic [IDX_W-1:0]            ptr,
  output logic                        any,
  output logic [IDX_W-1:0]            win_idx,
  output logic [NUM_REQ-1:0]          win_oh
);
  qos_t eff [NUM_REQ];

  genvar g;
  generate
    for (g = 0; g < NUM_REQ; g++) begin : g_eff
      assign eff[g] = boosted[g] ? QOS_TOP : qos[g*QOS_BITS +: QOS_BITS];
    end
  endgenerate

  always_comb begin
    logic found;
    qos_t best;
    int   pos;
    found   = 1'b0;
    best    = '0;
    win_idx = '0;
    for (int k = 0; k < NUM_REQ; k++) begin
      pos = int'(ptr) + k;
      if (pos >= NUM_REQ) pos = pos - NUM_REQ;
      if (valid[pos] && (!found || eff[pos] > best)) begin
        found   = 1'b1;
        best    = eff[pos];
        win_idx = IDX_W'(pos);
      end
    end
    any    = found;
    win_oh = found ? (NUM_REQ'(1) << win_idx) : '0;
  end
endmodule

// File: rtl/qos_age_arbiter.sv
module qos_age_arbiter
  import qos_arb_pkg::*;
#(
  parameter int NUM_REQ   = 4,
  parameter int QOS_W     = 4,
  parameter int AGE_W     = 6,
  parameter int AGE_LIMIT = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ*QOS_W-1:0] req_qos,
  input  logic                     xfer_done,
  output logic [NUM_REQ-1:0]       grant
);
  localparam int IDX_W = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REQ - 1);

  logic [NUM_REQ-1:0] grant_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [NUM_REQ-1:0] boosted;
  logic [NUM_REQ-1:0] win_oh;
  logic [IDX_W-1:0]   win_idx;
  logic               win_any;
  logic               busy;
  logic               fire;

  assign busy = |grant_q;
  assign fire = !busy && win_any;

  genvar g;
  generate
    for (g = 0; g < NUM_REQ; g++) begin : g_age
      qos_age_cell #(
        .AGE_W    (AGE_W),
        .AGE_LIMIT(AGE_LIMIT)
      ) i_cell (
        .clk    (clk),
        .rst    (rst),
        .inc    (req_valid[g] && !grant_q[g]),
        .clr    (fire && win_oh[g]),
        .boosted(boosted[g])
      );
    end
  endgenerate

  qos_pick #(
    .NUM_REQ(NUM_REQ),
    .IDX_W  (IDX_W)
  ) i_pick (
    .valid  (req_valid),
    .qos    (req_qos),
    .boosted(boosted),
    .ptr    (ptr_q),
    .any    (win_any),
    .win_idx(win_idx),
    .win_oh (win_oh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      ptr_q   <= '0;
    end else if (busy) begin
      if (xfer_done) grant_q <= '0;
    end else if (fire) begin
      grant_q <= win_oh;
      ptr_q   <= (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
    end
  end

  assign grant = grant_q;

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_q));

  // R2
  grant_to_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (|req_valid)) |=> ((grant_q & $past(req_valid)) != '0));

  // R2
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(|req_valid)) |=> (grant_q == '0));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !xfer_done) |=> $stable(grant_q));

  // R5
  grant_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && xfer_done) |=> (grant_q == '0));
endmodule

// File: tb/test_qos_age_arbiter.sv
module test_qos_age_arbiter;
  localparam int N     = 4;
  localparam int QW    = 4;
  localparam int AW    = 6;
  localparam int LIM   = 8;
  localparam int AMAX  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  req_valid;
  logic [N*QW-1:0] req_qos;
  logic          xfer_done;
  logic [N-1:0]  grant;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  qos_age_arbiter #(.NUM_REQ(N), .QOS_W(QW), .AGE_W(AW), .AGE_LIMIT(LIM)) i_qos_age_arbiter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_qos(req_qos),
    .xfer_done(xfer_done), .grant(grant)
  );

  // behavioural reference
  int           m_age [N];
  int           m_ptr;
  logic [N-1:0] m_grant;

  always @(posedge clk) begin
    if (rst) begin
      m_grant = '0;
      m_ptr   = 0;
      for (int i = 0; i < N; i++) m_age[i] = 0;
    end else if (m_grant != '0) begin
      for (int i = 0; i < N; i++)
        if (req_valid[i] && !m_grant[i] && m_age[i] < AMAX) m_age[i]++;
      if (xfer_done) m_grant = '0;
    end else if (req_valid != '0) begin
      int w, best, e, idx;
      w = -1; best = -1;
      for (int k = 0; k < N; k++) begin
        idx = (m_ptr + k) % N;
        e = (m_age[idx] > LIM) ? 15 : int'(req_qos[idx*QW +: QW]);
        if (req_valid[idx] && e > best) begin best = e; w = idx; end
      end
      for (int i = 0; i < N; i++)
        if (i != w && req_valid[i] && m_age[i] < AMAX) m_age[i]++;
      m_age[w] = 0;
      m_grant  = N'(1) << w;
      m_ptr    = (w + 1) % N;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      total++;
      if (grant !== m_grant) begin
        bad++;
        $display("FAIL model R3/R4/R6/R8 cycle %0d: actual=%b expected=%b", cyc, grant, m_grant);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog R5: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: actual=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic set_req(input int i, input logic v, input int q);
    req_valid[i] = v;
    req_qos[i*QW +: QW] = QW'(q);
  endtask

  task automatic pulse_done();
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic wait_grant();
    for (int t = 0; t < 50 && grant == '0; t++) @(negedge clk);
  endtask

  initial begin
    logic [N-1:0] seen;
    logic         hit;
    rst = 1'b1; req_valid = '0; req_qos = '0; xfer_done = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset grant", grant, 4'b0000);
    rst = 1'b0;

    // R2: lone requester
    set_req(2, 1'b1, 3);
    @(negedge clk);
    chk("R2 lone grant", grant, 4'b0100);
    set_req(2, 1'b0, 3);
    // R5: hold with no valid and no done
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk("R5 hold", grant, 4'b0100);
    end
    pulse_done();
    chk("R5 release", grant, 4'b0000);

    // R3: highest level wins
    set_req(0, 1'b1, 1); set_req(1, 1'b1, 9); set_req(3, 1'b1, 5);
    @(negedge clk);
    chk("R3 top level", grant, 4'b0010);
    pulse_done();
    set_req(1, 1'b0, 9);
    @(negedge clk);
    chk("R3 next level", grant, 4'b1000);
    req_valid = '0;
    pulse_done();

    // R4: equal levels rotate
    for (int i = 0; i < N; i++) set_req(i, 1'b1, 4);
    seen = '0;
    for (int r = 0; r < N; r++) begin
      wait_grant();
      seen = seen | grant;
      pulse_done();
    end
    chk("R4 rotation covers all", seen, 4'b1111);
    req_valid = '0;
    @(negedge clk);
    if (grant != '0) pulse_done();
    @(negedge clk);

    // R9: level 0 versus two level-15 streams
    set_req(0, 1'b1, 0); set_req(1, 1'b1, 15); set_req(2, 1'b1, 15);
    hit = 1'b0;
    for (int r = 0; r < 30 && !hit; r++) begin
      wait_grant();
      if (grant[0]) hit = 1'b1;
      pulse_done();
    end
    chk("R9 low level served", {3'b000, hit}, 4'b0001);
    req_valid = '0;
    @(negedge clk);
    if (grant != '0) pulse_done();
    @(negedge clk);

    // R8: two boosted requesters, rotation decides, beat level 14
    set_req(1, 1'b1, 5);
    @(negedge clk);
    chk("R8 setup holder", grant, 4'b0010);
    set_req(1, 1'b0, 5);
    set_req(0, 1'b1, 0); set_req(3, 1'b1, 0);
    repeat (12) @(negedge clk);
    set_req(2, 1'b1, 14);
    @(negedge clk);
    pulse_done();
    @(negedge clk);
    chk("R8 boosted rotation", grant, 4'b1000);
    set_req(3, 1'b0, 0);
    pulse_done();
    @(negedge clk);
    chk("R8 boosted beats 14", grant, 4'b0001);
    req_valid = '0;
    pulse_done();
    @(negedge clk);
    if (grant != '0) pulse_done();
    @(negedge clk);

    // R7: counter saturates past the wrap point
    set_req(3, 1'b1, 2);
    @(negedge clk);
    chk("R7 setup holder", grant, 4'b1000);
    set_req(3, 1'b0, 2);
    set_req(0, 1'b1, 0);
    repeat (64) @(negedge clk);
    set_req(1, 1'b1, 7);
    repeat (2) @(negedge clk);
    pulse_done();
    @(negedge clk);
    chk("R7 saturated boost", grant, 4'b0001);

    // R6: counter cleared on grant, requester stayed valid
    pulse_done();
    @(negedge clk);
    chk("R6 cleared on grant", grant, 4'b0010);
    req_valid = '0;
    pulse_done();
    repeat (2) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule